// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block watches a processor's instruction-fetch stream and its data-access stream against four programmable breakpoint slots. Each slot holds a linear address, an access-type code and a length code. When an armed slot matches, the block records which slot fired in a sticky status register and raises a one-cycle debug-exception request. It also generates single-step traps while a trap flag is active, and honours a resume flag that suppresses a fetch breakpoint on the instruction being resumed. A task-switch strobe from outside sets its own status bit.

Software reaches the slot addresses, the control register and the status register through a register port that only privilege level 0 may use. Select codes: 0 to 3 are the slot address registers, 4 is the status register, 5 is the control register. Other codes read zero and ignore writes. A refused access changes nothing, reads zero, and is reported as a debug-register access trap.

The single-step sequencer is a two-state machine. `ST_OFF` (trap flag clear) moves to `ST_ARMED` on any cycle in which `tf` is high. No trap is raised in that cycle, so the retire pulse that comes with the flag being set belongs to the instruction that set it. `ST_ARMED` raises a step trap on every `retire` pulse while `tf` stays high. It returns to `ST_OFF` in any cycle where `tf` is low, and raises no trap in that cycle.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset, dbg_status reads 0xFFFF0000, dbg_req is low, and the control and slot address registers read zero.
- R2: At privilege 0, the control register keeps only bits [31:16] and [7:0] and reads back 0 in bits [15:8]. Select codes are 0-3 for slot addresses, 4 for status and 5 for control.
- R3: Slot n is armed when control bit 2n (local) or bit 2n+1 (global) is set. A slot that is not armed never matches.
- R4: A slot with access type 00 matches a fetch whose address equals the slot address exactly. This sets status bit n and raises dbg_req in the cycle after the fetch.
- R5: Access type is at control bits [17+4n:16+4n]. Code 01 matches data writes only. Code 11 matches data reads and writes but never fetches. Code 10 matches data reads only while ext_en is high, and otherwise never matches.
- R6: Length is at control bits [19+4n:18+4n]: 00 is 1 byte, 01 is 2 bytes, 11 is 4 bytes, and 10 never matches. A data match requires the access bytes (data_size 00=1, 01=2, 1x=4 from data_addr) to overlap the window at the slot address with its low bits cleared to the length.
- R7: Status bits [3:0] and [15:13] are sticky until software writes the status register, and a write replaces them. An event in the same cycle as a write is still recorded. Bits [31:16] read as ones and all other bits read zero.
- R8: Single-step: no trap is raised for the instruction whose retirement set tf. Each later retire pulse while tf stays high sets status bit 14 and raises dbg_req. No trap is raised once tf is low.
- R9: An access with reg_cpl not 0 asserts reg_deny in the same cycle, returns zero read data and modifies no register. It sets status bit 13 and raises dbg_req in the next cycle.
- R10: A fetch with fetch_rf high never produces a fetch breakpoint match.
- R11: Several causes in one cycle set all their status bits and produce one dbg_req pulse of one cycle.
- R12: A task_sw strobe sets status bit 15 and raises dbg_req in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_cpl | input | 2 | Privilege level of the access |
| reg_rdata | output | 32 | Read data, same cycle |
| reg_deny | output | 1 | Access refused |
| ext_en | input | 1 | Enables access-type code 10 |
| fetch_valid | input | 1 | Instruction fetch present |
| fetch_addr | input | 32 | Fetch linear address |
| fetch_rf | input | 1 | Resume flag for this fetch |
| data_valid | input | 1 | Data access present |
| data_addr | input | 32 | Data linear address |
| data_size | input | 2 | Access size code |
| data_we | input | 1 | 1 = data write |
| retire | input | 1 | Instruction completed |
| tf | input | 1 | Trap flag level |
| task_sw | input | 1 | Task-switch trap strobe |
| dbg_req | output | 1 | Debug-exception request pulse |
| dbg_status | output | 32 | Status register view |

## Verification
On every cycle, the assertions check that a refused access leaves the address and control state untouched and raises the access-trap bit with a request. They also check that every request comes with a recorded cause, that a step trap is never raised without the flag having been high one cycle earlier, that a resumed fetch alone never produces a request, and that a write-only slot never matches a read. Only the bench's scenarios can show the exact window arithmetic for each length and size, the gating of code 10 by ext_en, the delay of the first step trap, and the read-back masks. The same holds for a single request covering two slots, and for an event winning over a status write in the same cycle.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
    localparam int NSLOT = 4;
    localparam int ADDR_W = 32;
    localparam int REG_W = 32;
    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_STAT = 3'd4;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd5;

    localparam logic [REG_W-1:0] CTRL_KEEP = 32'hFFFF_00FF;

    localparam int BIT_BD = 13;
    localparam int BIT_BS = 14;
    localparam int BIT_BT = 15;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_WR    = 2'b01,
        ACC_EXT   = 2'b10,
        ACC_RW    = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        LEN_1   = 2'b00,
        LEN_2   = 2'b01,
        LEN_BAD = 2'b10,
        LEN_4   = 2'b11
    } len_e;

    typedef enum logic {
        ST_OFF   = 1'b0,
        ST_ARMED = 1'b1
    } step_e;
endpackage

// File: rtl/dbg_slot_cmp.sv
module dbg_slot_cmp
    import dbg_bkpt_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          armed,
    input  logic [AW-1:0] bp_addr,
    input  acc_e          acc,
    input  len_e          len,
    input  logic          ext_en,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          fetch_rf,
    input  logic          data_valid,
    input  logic [AW-1:0] data_addr,
    input  logic [1:0]    data_size,
    input  logic          data_we,
    output logic          fetch_hit,
    output logic          data_hit
);
    logic [2:0]  win_bytes;
    logic [2:0]  acc_bytes;
    logic        len_ok;
    logic        type_ok;
    logic [AW-1:0] low_mask;
    logic [AW:0] win_lo, win_hi, acc_lo, acc_hi;
    logic        overlap;

    // window size from the length code
    always_comb begin
        unique case (len)
            LEN_1:   win_bytes = 3'd1;
            LEN_2:   win_bytes = 3'd2;
            LEN_4:   win_bytes = 3'd4;
            default: win_bytes = 3'd1;
        endcase
    end

    assign len_ok    = (len != LEN_BAD);
    assign acc_bytes = (data_size == 2'b00) ? 3'd1 :
                       (data_size == 2'b01) ? 3'd2 : 3'd4;

    assign low_mask = {{(AW-3){1'b0}}, win_bytes - 3'd1};
    assign win_lo   = {1'b0, bp_addr & ~low_mask};
    assign win_hi   = win_lo + {{(AW-2){1'b0}}, win_bytes - 3'd1};
    assign acc_lo   = {1'b0, data_addr};
    assign acc_hi   = acc_lo + {{(AW-2){1'b0}}, acc_bytes - 3'd1};
    assign overlap  = (acc_lo <= win_hi) && (acc_hi >= win_lo);

    always_comb begin
        unique case (acc)
            ACC_WR:  type_ok = data_we;
            ACC_RW:  type_ok = 1'b1;
            ACC_EXT: type_ok = ext_en && !data_we;
            default: type_ok = 1'b0;
        endcase
    end

    assign data_hit  = armed && len_ok && data_valid && type_ok && overlap;
    assign fetch_hit = armed && len_ok && (acc == ACC_FETCH) && fetch_valid &&
                       !fetch_rf && (fetch_addr == bp_addr);

    // R5: a write-only slot is blind to reads
    always_comb begin
        a_r5_write_slot_ignores_reads :
            assert (!((acc == ACC_WR) && data_valid && !data_we && data_hit))
            else $error("write-only slot matched a read");
    end
endmodule

// File: rtl/dbg_step_fsm.sv
module dbg_step_fsm
    import dbg_bkpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tf,
    input  logic retire,
    output logic step_trap
);
    step_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (tf)  state_d = ST_ARMED;
            ST_ARMED: if (!tf) state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        step_trap = 1'b0;
        unique case (state_q)
            ST_OFF:   step_trap = 1'b0;
            ST_ARMED: step_trap = tf && retire;
        endcase
    end

    // R8: a step trap needs the flag seen high one cycle earlier
    a_r8_trap_needs_prior_flag :
        assert property (@(posedge clk) disable iff (!rst_n)
            step_trap |-> $past(tf))
        else $error("step trap without prior flag");
endmodule

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
    import dbg_bkpt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NS = NSLOT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_req,
    input  logic                   reg_we,
    input  logic [SEL_W-1:0]       reg_sel,
    input  logic [REG_W-1:0]       reg_wdata,
    input  logic [1:0]             reg_cpl,
    output logic                   reg_ok,
    output logic                   reg_deny,
    output logic [NS-1:0][AW-1:0]  bp_addr,
    output logic [REG_W-1:0]       ctrl
);
    assign reg_ok   = reg_req && (reg_cpl == 2'd0);
    assign reg_deny = reg_req && (reg_cpl != 2'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            bp_addr <= '0;
        end else if (reg_ok && reg_we) begin
            if (reg_sel == SEL_CTRL) ctrl <= reg_wdata & CTRL_KEEP;
            for (int i = 0; i < NS; i++) begin
                if (reg_sel == SEL_W'(i)) bp_addr[i] <= AW'(reg_wdata);
            end
        end
    end

    // R9: a refused write leaves all configuration unchanged
    a_r9_refused_write_holds :
        assert property (@(posedge clk) disable iff (!rst_n)
            (reg_req && reg_we && (reg_cpl != 2'd0)) |=> ($stable(ctrl) && $stable(bp_addr)))
        else $error("refused write altered configuration");
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
    import dbg_bkpt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NS = NSLOT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_req,
    input  logic             reg_we,
    input  logic [2:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic [1:0]       reg_cpl,
    output logic [31:0]      reg_rdata,
    output logic             reg_deny,
    input  logic             ext_en,
    input  logic             fetch_valid,
    input  logic [AW-1:0]    fetch_addr,
    input  logic             fetch_rf,
    input  logic             data_valid,
    input  logic [AW-1:0]    data_addr,
    input  logic [1:0]       data_size,
    input  logic             data_we,
    input  logic             retire,
    input  logic             tf,
    input  logic             task_sw,
    output logic             dbg_req,
    output logic [31:0]      dbg_status
);
    logic                  reg_ok;
    logic [NS-1:0][AW-1:0] bp_addr;
    logic [REG_W-1:0]      ctrl;
    logic [NS-1:0]         f_hit, d_hit, slot_hit;
    logic                  step_trap;

    logic [NS-1:0] b_q, b_d;
    logic          bd_q, bs_q, bt_q, bd_d, bs_d, bt_d;
    logic          req_q, ev_any, stat_wr;

    dbg_cfg_regs #(.AW(AW), .NS(NS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_cpl(reg_cpl),
        .reg_ok(reg_ok), .reg_deny(reg_deny), .bp_addr(bp_addr), .ctrl(ctrl)
    );

    for (genvar n = 0; n < NS; n++) begin : g_slot
        dbg_slot_cmp #(.AW(AW)) u_cmp (
            .armed      (ctrl[2*n] | ctrl[2*n+1]),
            .bp_addr    (bp_addr[n]),
            .acc        (acc_e'(ctrl[16+4*n +: 2])),
            .len        (len_e'(ctrl[18+4*n +: 2])),
            .ext_en     (ext_en),
            .fetch_valid(fetch_valid),
            .fetch_addr (fetch_addr),
            .fetch_rf   (fetch_rf),
            .data_valid (data_valid),
            .data_addr  (data_addr),
            .data_size  (data_size),
            .data_we    (data_we),
            .fetch_hit  (f_hit[n]),
            .data_hit   (d_hit[n])
        );
        assign slot_hit[n] = f_hit[n] | d_hit[n];
    end

    dbg_step_fsm u_step (
        .clk(clk), .rst_n(rst_n), .tf(tf), .retire(retire), .step_trap(step_trap)
    );

    assign stat_wr = reg_ok && reg_we && (reg_sel == SEL_STAT);
    assign ev_any  = (|slot_hit) | step_trap | reg_deny | task_sw;

    // software write replaces, events are OR-ed on top
    always_comb begin
        if (stat_wr) begin
            b_d  = reg_wdata[NS-1:0];
            bd_d = reg_wdata[BIT_BD];
            bs_d = reg_wdata[BIT_BS];
            bt_d = reg_wdata[BIT_BT];
        end else begin
            b_d  = b_q;
            bd_d = bd_q;
            bs_d = bs_q;
            bt_d = bt_q;
        end
        b_d  = b_d | slot_hit;
        bd_d = bd_d | reg_deny;
        bs_d = bs_d | step_trap;
        bt_d = bt_d | task_sw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q   <= '0;
            bd_q  <= 1'b0;
            bs_q  <= 1'b0;
            bt_q  <= 1'b0;
            req_q <= 1'b0;
        end else begin
            b_q   <= b_d;
            bd_q  <= bd_d;
            bs_q  <= bs_d;
            bt_q  <= bt_d;
            req_q <= ev_any;
        end
    end

    always_comb begin
        dbg_status              = 32'hFFFF_0000;
        dbg_status[NS-1:0]      = b_q;
        dbg_status[BIT_BD]      = bd_q;
        dbg_status[BIT_BS]      = bs_q;
        dbg_status[BIT_BT]      = bt_q;
    end

    assign dbg_req = req_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_ok && !reg_we) begin
            if (reg_sel == SEL_STAT)      reg_rdata = dbg_status;
            else if (reg_sel == SEL_CTRL) reg_rdata = ctrl;
            else begin
                for (int i = 0; i < NS; i++) begin
                    if (reg_sel == SEL_W'(i)) reg_rdata = REG_W'(bp_addr[i]);
                end
            end
        end
    end

    // R9: refusal is reported as an access trap
    a_r9_refused_sets_bd :
        assert property (@(posedge clk) disable iff (!rst_n)
            (reg_req && (reg_cpl != 2'd0)) |=> (dbg_status[BIT_BD] && dbg_req))
        else $error("refused access not reported");

    // R11: every request carries a recorded cause
    a_r11_req_has_cause :
        assert property (@(posedge clk) disable iff (!rst_n)
            dbg_req |-> ((dbg_status[15:13] != 3'b000) || (dbg_status[NS-1:0] != '0)))
        else $error("request without cause");

    // R10: a resumed fetch on its own never raises a request
    a_r10_resume_masks_fetch :
        assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_valid && fetch_rf && !data_valid && !retire && !task_sw && !reg_req)
            |=> !dbg_req)
        else $error("resumed fetch raised request");
endmodule

// File: tb/dbg_bkpt_unit_test.sv
`timescale 1ns/1ps
module dbg_bkpt_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 0, reg_we = 0;
    logic [2:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [1:0]  reg_cpl = 0;
    logic [31:0] reg_rdata;
    logic        reg_deny;
    logic        ext_en = 0, fetch_valid = 0, fetch_rf = 0;
    logic [31:0] fetch_addr = 0, data_addr = 0;
    logic        data_valid = 0, data_we = 0;
    logic [1:0]  data_size = 0;
    logic        retire = 0, tf = 0, task_sw = 0;
    logic        dbg_req;
    logic [31:0] dbg_status;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dbg_bkpt_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_cpl(reg_cpl),
        .reg_rdata(reg_rdata), .reg_deny(reg_deny), .ext_en(ext_en),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_rf(fetch_rf),
        .data_valid(data_valid), .data_addr(data_addr), .data_size(data_size),
        .data_we(data_we), .retire(retire), .tf(tf), .task_sw(task_sw),
        .dbg_req(dbg_req), .dbg_status(dbg_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        reg_req = 1; reg_we = 1; reg_sel = sel; reg_wdata = d; reg_cpl = 0;
        tick();
        reg_req = 0; reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] sel, input logic [1:0] cpl, output logic [31:0] d);
        reg_req = 1; reg_we = 0; reg_sel = sel; reg_cpl = cpl;
        #1 d = reg_rdata;
        tick();
        reg_req = 0; reg_cpl = 0;
    endtask

    task automatic clr();
        wr(3'd4, 32'h0);
    endtask

    task automatic fetch(input logic [31:0] a, input logic rf);
        fetch_valid = 1; fetch_addr = a; fetch_rf = rf;
        tick();
        fetch_valid = 0; fetch_rf = 0;
    endtask

    task automatic dacc(input logic [31:0] a, input logic [1:0] sz, input logic we);
        data_valid = 1; data_addr = a; data_size = sz; data_we = we;
        tick();
        data_valid = 0; data_we = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 status", dbg_status, 32'hFFFF_0000);
        chk("R1 req", {31'b0, dbg_req}, 32'h0);
        rd(3'd5, 2'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(3'd2, 2'd0, v); chk("R1 addr2", v, 32'h0);
    endtask

    task automatic t_ctrl_mask();
        logic [31:0] v;
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, 2'd0, v); chk("R2 ctrl mask", v, 32'hFFFF_00FF);
        wr(3'd5, 32'h0);
        wr(3'd1, 32'h1234_5678);
        rd(3'd1, 2'd0, v); chk("R2 addr readback", v, 32'h1234_5678);
    endtask

    task automatic t_fetch();
        wr(3'd0, 32'h1000);
        wr(3'd5, 32'h0000_0001);
        clr();
        fetch(32'h1000, 0);
        chk("R4 fetch req", {31'b0, dbg_req}, 32'h1);
        chk("R4 fetch B0", dbg_status, 32'hFFFF_0001);
        tick();
        chk("R11 req one cycle", {31'b0, dbg_req}, 32'h0);
        chk("R7 sticky", dbg_status, 32'hFFFF_0001);
        clr();
        chk("R7 cleared", dbg_status, 32'hFFFF_0000);
        fetch(32'h1001, 0);
        chk("R4 exact address", {31'b0, dbg_req}, 32'h0);
        fetch(32'h1000, 1);
        chk("R10 resume masks", {31'b0, dbg_req}, 32'h0);
        chk("R10 no status", dbg_status, 32'hFFFF_0000);
    endtask

    task automatic t_data();
        // slot1: write-only, 4 bytes at 0x2002; slot2: rw 2 bytes at 0x3000; slot3: code 10
        wr(3'd1, 32'h2002);
        wr(3'd2, 32'h3000);
        wr(3'd3, 32'h4000);
        wr(3'd5, 32'h27D0_0099);
        clr();
        dacc(32'h2003, 2'b00, 1);
        chk("R6 window top byte", dbg_status, 32'hFFFF_0002);
        clr();
        dacc(32'h2001, 2'b00, 0);
        chk("R5 write-only ignores read", dbg_status, 32'hFFFF_0000);
        dacc(32'h1FFF, 2'b01, 1);
        chk("R6 straddle low edge", dbg_status, 32'hFFFF_0002);
        clr();
        dacc(32'h2004, 2'b11, 1);
        chk("R6 past window", dbg_status, 32'hFFFF_0000);
        dacc(32'h3001, 2'b00, 0);
        chk("R5 rw read hit", dbg_status, 32'hFFFF_0004);
        clr();
        fetch(32'h3000, 0);
        chk("R5 rw ignores fetch", dbg_status, 32'hFFFF_0000);
        dacc(32'h4000, 2'b00, 0);
        chk("R5 code10 off", dbg_status, 32'hFFFF_0000);
        ext_en = 1;
        dacc(32'h4000, 2'b00, 0);
        chk("R5 code10 read with ext", dbg_status, 32'hFFFF_0008);
        clr();
        dacc(32'h4000, 2'b00, 1);
        chk("R5 code10 write ignored", dbg_status, 32'hFFFF_0000);
        ext_en = 0;
    endtask

    task automatic t_multi();
        wr(3'd2, 32'h2004);
        clr();
        dacc(32'h2003, 2'b01, 1);
        chk("R11 both slots", dbg_status, 32'hFFFF_0006);
        chk("R11 single req", {31'b0, dbg_req}, 32'h1);
        tick();
        chk("R11 req drops", {31'b0, dbg_req}, 32'h0);
        clr();
    endtask

    task automatic t_len_arm();
        // slot0 length 10 with write type; slot3 fields set but no enable
        wr(3'd0, 32'h5000);
        wr(3'd5, 32'h2009_0001);
        clr();
        dacc(32'h5000, 2'b00, 1);
        chk("R6 undefined length", dbg_status, 32'hFFFF_0000);
        ext_en = 1;
        dacc(32'h4000, 2'b00, 0);
        chk("R3 unarmed slot", dbg_status, 32'hFFFF_0000);
        chk("R3 no req", {31'b0, dbg_req}, 32'h0);
        ext_en = 0;
        wr(3'd5, 32'h0);
    endtask

    task automatic t_step();
        clr();
        tf = 1; retire = 1;
        tick();
        retire = 0;
        chk("R8 setter no trap", {31'b0, dbg_req}, 32'h0);
        tick();
        chk("R8 setter no BS", dbg_status, 32'hFFFF_0000);
        retire = 1;
        tick();
        retire = 0;
        chk("R8 next instr trap", dbg_status, 32'hFFFF_4000);
        chk("R8 trap req", {31'b0, dbg_req}, 32'h1);
        clr();
        tf = 0; retire = 1;
        tick();
        retire = 0;
        chk("R8 flag cleared", dbg_status, 32'hFFFF_0000);
    endtask

    task automatic t_priv();
        logic [31:0] v;
        wr(3'd5, 32'h0000_0001);
        clr();
        reg_req = 1; reg_we = 1; reg_sel = 3'd5; reg_wdata = 32'hFFFF_FFFF; reg_cpl = 2'd3;
        #1 chk("R9 deny flag", {31'b0, reg_deny}, 32'h1);
        tick();
        reg_req = 0; reg_we = 0; reg_cpl = 0;
        chk("R9 BD set", dbg_status, 32'hFFFF_2000);
        chk("R9 req", {31'b0, dbg_req}, 32'h1);
        rd(3'd5, 2'd0, v); chk("R9 ctrl unchanged", v, 32'h0000_0001);
        rd(3'd0, 2'd3, v); chk("R9 read zero", v, 32'h0);
        wr(3'd5, 32'h0);
    endtask

    task automatic t_task_and_write();
        logic [31:0] v;
        clr();
        task_sw = 1;
        tick();
        task_sw = 0;
        chk("R12 BT", dbg_status, 32'hFFFF_8000);
        chk("R12 req", {31'b0, dbg_req}, 32'h1);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, 2'd0, v); chk("R7 write mask", v, 32'hFFFF_E00F);
        reg_req = 1; reg_we = 1; reg_sel = 3'd4; reg_wdata = 32'h0; task_sw = 1;
        tick();
        reg_req = 0; reg_we = 0; task_sw = 0;
        chk("R7 event beats write", dbg_status, 32'hFFFF_8000);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        t_reset();
        t_ctrl_mask();
        t_fetch();
        t_data();
        t_multi();
        t_len_arm();
        t_step();
        t_priv();
        t_task_and_write();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule